// File: doc/BRIEF.md
# Receive Frame Acceptance and Status Generator

This block watches the byte stream of an Ethernet receiver on its way into a receive FIFO and decides the fate of each frame. It counts the bytes, captures the destination address from the first six bytes, and classifies that address as individual, group or all-ones broadcast. It then asks an external address matcher for a verdict. The matcher answers combinationally in the cycle the request strobe is high. A frame is committed to the FIFO only once a full 64-byte collision window has arrived and the address check has not thrown it out. Collision fragments and frames the matcher refuses are discarded.

Frames longer than a programmable maximum are passed through whole. Such a frame raises a one-cycle babbling-receiver event and sets a long-frame flag. When a committed frame ends, the block emits a 32-bit status word together with a frame-done pulse. The word holds the byte count and eight condition flags. Four of those flags come from end-of-frame inputs supplied by the CRC checker and the receive datapath. Discarded frames produce no status word. The block is ready for the next frame from the cycle after a last byte, so frames may arrive back to back.

Top module: `rx_frame_gate`

## Requirements
- R1: One cycle after the sixth byte of a frame (when that byte is not the last), `da_req` pulses for one cycle. `da_addr` holds the six address bytes, with the first received byte in bits [7:0].
- R2: An all-ones address is broadcast and sets status bit 22. An address whose first byte has bit 0 set but is not all ones is multicast and sets bit 21. Any other address sets neither bit.
- R3: If `da_hit` is low and `promisc` is low during `da_req`, `fifo_discard` pulses once in the following cycle. That frame then gets no commit and no status word.
- R4: If `da_hit` is low while `promisc` is high during `da_req`, the frame proceeds normally and its status word has the miss bit 23 set.
- R5: For a frame that has not been discarded, `fifo_commit` pulses for one cycle, once per frame, in the cycle after the 64th byte is accepted.
- R6: A frame whose last byte comes before byte 64 and that was not already discarded gets one `fifo_discard` pulse in the cycle after its last byte, and no status word. A frame never gets more than one discard pulse.
- R7: In the cycle after the last byte of a committed frame, `frame_done` pulses and `frame_status` holds the following fields, with bits [31:24] zero:
  - bits [15:0]: the byte count;
  - bit 16: truncated;
  - bit 17: overrun;
  - bit 18: CRC error;
  - bit 19: non-octet.
  The four flags in bits 16 to 19 are taken from the end inputs sampled with the last byte.
- R8: A frame longer than the maximum length is not cut short: it is committed and reports its full length. Status bit 20 is set for it. `babble` pulses once, in the cycle after the byte whose number is the maximum plus one. A frame of exactly the maximum length does neither.
- R9: The maximum-length register holds 1518 after reset and takes the value of `cfg_maxlen_data` in any cycle in which `cfg_maxlen_we` is high.
- R10: Cycles with `rx_valid` low are ignored whatever `rx_data` and `rx_last` carry. After a last byte, the next valid byte starts a new frame, even in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_maxlen_we | input | 1 | Write strobe for the maximum frame length |
| cfg_maxlen_data | input | 11 | New maximum frame length in bytes |
| rx_valid | input | 1 | A received byte is present |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | This byte ends the frame |
| rx_end_trunc | input | 1 | Truncation flag, sampled with the last byte |
| rx_end_overrun | input | 1 | Overrun flag, sampled with the last byte |
| rx_end_crc_err | input | 1 | CRC error flag, sampled with the last byte |
| rx_end_dribble | input | 1 | Non-octet ending flag, sampled with the last byte |
| da_req | output | 1 | Address verdict request strobe |
| da_addr | output | 48 | Captured destination address |
| da_hit | input | 1 | Matcher verdict, valid while da_req is high |
| promisc | input | 1 | Accept unmatched frames and mark them as misses |
| fifo_commit | output | 1 | Commit the current frame in the FIFO |
| fifo_discard | output | 1 | Discard the current frame from the FIFO |
| babble | output | 1 | Babbling-receiver event |
| frame_done | output | 1 | Status word valid, frame received |
| frame_status | output | 32 | Frame status word |

## Verification
The bench targets the frame lengths on either side of the collision window:
- 63 bytes must be discarded, while 64 bytes must be committed and reported. A window compare that is off by one swaps these outcomes or moves the commit pulse by a byte.
- A 7-byte frame refused by the matcher has its runt end in the same cycle as the address reject. A design that does not merge the two causes emits two discard pulses, or none.
- A frame exactly at the maximum length must not raise the long-frame bit, while one byte more must. A wrong comparison sense shows up there, or as a babble pulse at the wrong byte.
- Back-to-back frames and frames with idle gaps check that the counter restarts and that idle cycles carrying stray data or last flags change nothing.

// File: rtl/rxg_pkg.sv
package rxg_pkg;

  localparam int STAT_LEN_W = 16;
  localparam int DA_BYTES   = 6;
  localparam int DA_W       = 8 * DA_BYTES;

  typedef enum logic [1:0] {
    DA_UNI   = 2'd0,
    DA_MULTI = 2'd1,
    DA_BCAST = 2'd2
  } da_kind_e;

  // Packed so that miss lands on the most significant bit (status bit 23)
  // and trunc on the least significant bit (status bit 16).
  typedef struct packed {
    logic miss;
    logic bcast;
    logic mcast;
    logic longf;
    logic nonoct;
    logic crc;
    logic ovr;
    logic trunc;
  } rx_flags_t;

  function automatic da_kind_e classify_da(input logic [DA_W-1:0] da);
    if (&da)       return DA_BCAST;
    else if (da[0]) return DA_MULTI;
    else           return DA_UNI;
  endfunction

endpackage

// File: rtl/rxg_len_ctr.sv
module rxg_len_ctr #(
  parameter int LEN_W    = 16,
  parameter int MAXL_W   = 11,
  parameter int MAXL_RST = 1518
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [MAXL_W-1:0] cfg_data,
  input  logic              byte_en,
  input  logic              byte_last,
  output logic [LEN_W-1:0]  cnt_q,
  output logic [LEN_W-1:0]  cnt_inc,
  output logic [MAXL_W-1:0] max_len,
  output logic              babble_o
);

  localparam int PAD = LEN_W - MAXL_W;

  logic [LEN_W-1:0]  cnt_d;
  logic [MAXL_W-1:0] maxl_q, maxl_d;
  logic [LEN_W-1:0]  babble_at;
  logic              babble_d;

  always_comb begin
    cnt_inc   = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
    cnt_d     = cnt_q;
    if (byte_en) cnt_d = byte_last ? '0 : cnt_inc;
    maxl_d    = cfg_we ? cfg_data : maxl_q;
    babble_at = {{PAD{1'b0}}, maxl_q} + 1'b1;
    babble_d  = byte_en && (cnt_inc == babble_at);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      maxl_q   <= MAXL_W'(MAXL_RST);
      babble_o <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      maxl_q   <= maxl_d;
      babble_o <= babble_d;
    end
  end

  assign max_len = maxl_q;

  // R8: the babble event is a single-cycle pulse per frame
  a_r8_babble_single: assert property (@(posedge clk) disable iff (!rst_n)
    babble_o |=> !babble_o);

  // R10: a last byte always leaves the counter at zero
  a_r10_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_en && byte_last) |=> (cnt_q == '0));

endmodule

// File: rtl/rxg_da_cap.sv
module rxg_da_cap #(
  parameter int LEN_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    byte_en,
  input  logic                    byte_last,
  input  logic [7:0]              byte_data,
  input  logic [LEN_W-1:0]        cnt_q,
  output logic                    da_req_o,
  output logic [rxg_pkg::DA_W-1:0] da_o,
  output rxg_pkg::da_kind_e       kind_o
);
  import rxg_pkg::*;

  logic     req_d;
  da_kind_e kind_d;

  for (genvar g = 0; g < DA_BYTES; g++) begin : g_da_byte
    logic [7:0] b_q, b_d;
    always_comb begin
      b_d = b_q;
      if (byte_en && (cnt_q == LEN_W'(g))) b_d = byte_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) b_q <= '0;
      else        b_q <= b_d;
    end
    assign da_o[8*g +: 8] = b_q;
  end

  always_comb begin
    req_d  = byte_en && !byte_last && (cnt_q == LEN_W'(DA_BYTES - 1));
    kind_d = da_req_o ? classify_da(da_o) : kind_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      da_req_o <= 1'b0;
      kind_o   <= DA_UNI;
    end else begin
      da_req_o <= req_d;
      kind_o   <= kind_d;
    end
  end

  // R1: the request follows directly on the sixth byte
  a_r1_req_after_da: assert property (@(posedge clk) disable iff (!rst_n)
    da_req_o |-> $past(byte_en && (cnt_q == LEN_W'(DA_BYTES - 1))));

  // R1: the request is a single-cycle pulse
  a_r1_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    da_req_o |=> !da_req_o);

endmodule

// File: rtl/rxg_verdict.sv
module rxg_verdict #(
  parameter int LEN_W     = 16,
  parameter int MAXL_W    = 11,
  parameter int WIN_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_en,
  input  logic              byte_last,
  input  logic [LEN_W-1:0]  cnt_inc,
  input  logic [MAXL_W-1:0] max_len,
  input  logic              da_req,
  input  logic              da_hit,
  input  logic              promisc,
  input  rxg_pkg::da_kind_e kind,
  input  logic              end_trunc,
  input  logic              end_ovr,
  input  logic              end_crc,
  input  logic              end_nonoct,
  output logic              commit_o,
  output logic              discard_o,
  output logic              done_o,
  output logic [31:0]       status_o
);
  import rxg_pkg::*;

  localparam int PAD = LEN_W - MAXL_W;
  localparam logic [LEN_W-1:0] WIN_L = LEN_W'(WIN_BYTES);

  logic      acc_q, acc_d, rej_q, rej_d, miss_q, miss_d;
  logic      drop_now, miss_now, end_now, win_hit, rej_eff;
  logic      commit_d, discard_d, done_d;
  rx_flags_t flags_d;
  logic [31:0] status_d;

  always_comb begin
    drop_now  = da_req && !da_hit && !promisc;
    miss_now  = da_req && !da_hit && promisc;
    end_now   = byte_en && byte_last;
    win_hit   = byte_en && (cnt_inc == WIN_L);
    rej_eff   = rej_q || drop_now;

    commit_d  = win_hit && !rej_eff;
    discard_d = drop_now || (end_now && (cnt_inc < WIN_L) && !rej_q);
    done_d    = end_now && !rej_eff && (acc_q || commit_d);

    acc_d     = end_now ? 1'b0 : (acc_q || commit_d);
    rej_d     = end_now ? 1'b0 : rej_eff;
    miss_d    = end_now ? 1'b0 : (miss_q || miss_now);

    flags_d.miss   = miss_q || miss_now;
    flags_d.bcast  = (kind == DA_BCAST);
    flags_d.mcast  = (kind == DA_MULTI);
    flags_d.longf  = cnt_inc > {{PAD{1'b0}}, max_len};
    flags_d.nonoct = end_nonoct;
    flags_d.crc    = end_crc;
    flags_d.ovr    = end_ovr;
    flags_d.trunc  = end_trunc;

    status_d = done_d ? {8'h00, flags_d, cnt_inc} : status_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= 1'b0;
      rej_q     <= 1'b0;
      miss_q    <= 1'b0;
      commit_o  <= 1'b0;
      discard_o <= 1'b0;
      done_o    <= 1'b0;
      status_o  <= '0;
    end else begin
      acc_q     <= acc_d;
      rej_q     <= rej_d;
      miss_q    <= miss_d;
      commit_o  <= commit_d;
      discard_o <= discard_d;
      done_o    <= done_d;
      status_o  <= status_d;
    end
  end

  // R3, R6: a frame is never both committed and discarded in one cycle
  a_r3_verdict_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_o && discard_o));

  // R5: a commit follows directly on the window byte
  a_r5_commit_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> $past(byte_en && (cnt_inc == WIN_L)));

  // R7: a reported frame is never shorter than the collision window
  a_r7_done_min_len: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (status_o[15:0] >= WIN_L));

  // R2: a status word never carries both address classes
  a_r2_class_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !(status_o[22] && status_o[21]));

  // R6: the discard indication is a single-cycle pulse
  a_r6_discard_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    discard_o |=> !discard_o);

endmodule

// File: rtl/rx_frame_gate.sv
module rx_frame_gate #(
  parameter int MAXL_W    = 11,
  parameter int MAXL_RST  = 1518,
  parameter int WIN_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_maxlen_we,
  input  logic [MAXL_W-1:0] cfg_maxlen_data,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic              rx_end_trunc,
  input  logic              rx_end_overrun,
  input  logic              rx_end_crc_err,
  input  logic              rx_end_dribble,
  output logic              da_req,
  output logic [47:0]       da_addr,
  input  logic              da_hit,
  input  logic              promisc,
  output logic              fifo_commit,
  output logic              fifo_discard,
  output logic              babble,
  output logic              frame_done,
  output logic [31:0]       frame_status
);
  import rxg_pkg::*;

  localparam int LEN_W = STAT_LEN_W;

  logic [1:0]        rst_sync_q;
  logic              rst_ni;
  logic [LEN_W-1:0]  cnt_q, cnt_inc;
  logic [MAXL_W-1:0] max_len;
  da_kind_e          kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  rxg_len_ctr #(
    .LEN_W   (LEN_W),
    .MAXL_W  (MAXL_W),
    .MAXL_RST(MAXL_RST)
  ) u_len (
    .clk      (clk),
    .rst_n    (rst_ni),
    .cfg_we   (cfg_maxlen_we),
    .cfg_data (cfg_maxlen_data),
    .byte_en  (rx_valid),
    .byte_last(rx_last),
    .cnt_q    (cnt_q),
    .cnt_inc  (cnt_inc),
    .max_len  (max_len),
    .babble_o (babble)
  );

  rxg_da_cap #(
    .LEN_W(LEN_W)
  ) u_da (
    .clk      (clk),
    .rst_n    (rst_ni),
    .byte_en  (rx_valid),
    .byte_last(rx_last),
    .byte_data(rx_data),
    .cnt_q    (cnt_q),
    .da_req_o (da_req),
    .da_o     (da_addr),
    .kind_o   (kind)
  );

  rxg_verdict #(
    .LEN_W    (LEN_W),
    .MAXL_W   (MAXL_W),
    .WIN_BYTES(WIN_BYTES)
  ) u_verdict (
    .clk       (clk),
    .rst_n     (rst_ni),
    .byte_en   (rx_valid),
    .byte_last (rx_last),
    .cnt_inc   (cnt_inc),
    .max_len   (max_len),
    .da_req    (da_req),
    .da_hit    (da_hit),
    .promisc   (promisc),
    .kind      (kind),
    .end_trunc (rx_end_trunc),
    .end_ovr   (rx_end_overrun),
    .end_crc   (rx_end_crc_err),
    .end_nonoct(rx_end_dribble),
    .commit_o  (fifo_commit),
    .discard_o (fifo_discard),
    .done_o    (frame_done),
    .status_o  (frame_status)
  );

  // R8: babble never fires for a frame still within the maximum length
  a_r8_babble_beyond_max: assert property (@(posedge clk) disable iff (!rst_ni)
    babble |-> ($past(cnt_inc) > {{(LEN_W-MAXL_W){1'b0}}, $past(max_len)}));

endmodule

// File: tb/rx_frame_gate_test.sv
`timescale 1ns/1ps
module rx_frame_gate_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_maxlen_we;
  logic [10:0] cfg_maxlen_data;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        rx_last;
  logic        rx_end_trunc, rx_end_overrun, rx_end_crc_err, rx_end_dribble;
  logic        da_req;
  logic [47:0] da_addr;
  logic        da_hit, promisc;
  logic        fifo_commit, fifo_discard, babble, frame_done;
  logic [31:0] frame_status;

  always #5 clk = ~clk;

  rx_frame_gate uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_maxlen_we(cfg_maxlen_we), .cfg_maxlen_data(cfg_maxlen_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .rx_end_trunc(rx_end_trunc), .rx_end_overrun(rx_end_overrun),
    .rx_end_crc_err(rx_end_crc_err), .rx_end_dribble(rx_end_dribble),
    .da_req(da_req), .da_addr(da_addr), .da_hit(da_hit), .promisc(promisc),
    .fifo_commit(fifo_commit), .fifo_discard(fifo_discard), .babble(babble),
    .frame_done(frame_done), .frame_status(frame_status)
  );

  int n_chk = 0;
  int n_err = 0;

  // byte position within the current frame, as seen at the clock edge
  int   pos = 0;
  logic after_last = 1'b1;
  always @(posedge clk) begin
    if (rx_valid) begin
      pos        <= after_last ? 1 : pos + 1;
      after_last <= rx_last;
    end
  end

  // output monitor, sampled on the falling edge
  int n_req = 0, n_commit = 0, n_discard = 0, n_babble = 0, n_done = 0;
  int req_at = 0, commit_at = 0, discard_at = 0, babble_at = 0;
  logic [47:0] req_addr = '0;
  logic [31:0] last_stat = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (da_req)       begin n_req++;     req_at = pos; req_addr = da_addr; end
      if (fifo_commit)  begin n_commit++;  commit_at = pos; end
      if (fifo_discard) begin n_discard++; discard_at = pos; end
      if (babble)       begin n_babble++;  babble_at = pos; end
      if (frame_done)   begin n_done++;    last_stat = frame_status; end
    end
  end

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic set_max(input logic [10:0] v);
    @(negedge clk);
    cfg_maxlen_we = 1'b1; cfg_maxlen_data = v;
    @(negedge clk);
    cfg_maxlen_we = 1'b0;
  endtask

  // fl bit order: [0] truncated, [1] overrun, [2] CRC error, [3] non-octet
  task automatic send_frame(input int len, input logic [7:0] b0, input logic [7:0] fill,
                            input logic hit, input logic prom, input logic [3:0] fl,
                            input bit gap, input int tail);
    da_hit  = hit;
    promisc = prom;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = (i == 0) ? b0 : (i < 6) ? fill : 8'(i);
      rx_last  = (i == len - 1);
      {rx_end_dribble, rx_end_crc_err, rx_end_overrun, rx_end_trunc} = (i == len - 1) ? fl : 4'b0;
      if (gap && i != len - 1) begin
        @(negedge clk);
        rx_valid = 1'b0; rx_data = 8'hFF; rx_last = 1'b1;
        {rx_end_dribble, rx_end_crc_err, rx_end_overrun, rx_end_trunc} = 4'hF;
      end
    end
    if (tail > 0) begin
      @(negedge clk);
      rx_valid = 1'b0; rx_last = 1'b0;
      {rx_end_dribble, rx_end_crc_err, rx_end_overrun, rx_end_trunc} = 4'b0;
      repeat (tail - 1) @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic [15:0] len;
    logic [7:0]  b0;
    logic [7:0]  fill;
    logic        hit;
    logic        prom;
    logic [3:0]  fl;
    logic [10:0] maxl;
    logic        e_commit;
    logic        e_discard;
    logic        e_done;
    logic        e_babble;
    logic [7:0]  e_flags;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{16'd64,  8'h02, 8'h11, 1'b1, 1'b0, 4'h0, 11'd1518, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00}, // R5 R7 exact window, unicast
    '{16'd100, 8'hFF, 8'hFF, 1'b1, 1'b0, 4'h0, 11'd1518, 1'b1, 1'b0, 1'b1, 1'b0, 8'h40}, // R2 broadcast
    '{16'd80,  8'h01, 8'h00, 1'b1, 1'b0, 4'h0, 11'd1518, 1'b1, 1'b0, 1'b1, 1'b0, 8'h20}, // R2 multicast
    '{16'd70,  8'hFF, 8'hFE, 1'b1, 1'b0, 4'h0, 11'd1518, 1'b1, 1'b0, 1'b1, 1'b0, 8'h20}, // R2 nearly all ones
    '{16'd90,  8'h02, 8'h33, 1'b0, 1'b0, 4'h0, 11'd1518, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, // R3 address reject
    '{16'd90,  8'h04, 8'h33, 1'b0, 1'b1, 4'h0, 11'd1518, 1'b1, 1'b0, 1'b1, 1'b0, 8'h80}, // R4 promiscuous miss
    '{16'd63,  8'h02, 8'h11, 1'b1, 1'b0, 4'h0, 11'd1518, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, // R6 one short of window
    '{16'd10,  8'h02, 8'h11, 1'b1, 1'b0, 4'h0, 11'd1518, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, // R6 short runt
    '{16'd64,  8'h02, 8'h11, 1'b1, 1'b0, 4'h5, 11'd1518, 1'b1, 1'b0, 1'b1, 1'b0, 8'h05}, // R7 TR and CR
    '{16'd200, 8'h02, 8'h11, 1'b1, 1'b0, 4'hA, 11'd1518, 1'b1, 1'b0, 1'b1, 1'b0, 8'h0A}, // R7 OV and NO
    '{16'd120, 8'h02, 8'h11, 1'b1, 1'b0, 4'h0, 11'd100,  1'b1, 1'b0, 1'b1, 1'b1, 8'h10}, // R8 long frame
    '{16'd100, 8'h02, 8'h11, 1'b1, 1'b0, 4'h0, 11'd100,  1'b1, 1'b0, 1'b1, 1'b0, 8'h00}, // R8 exactly max
    '{16'd5,   8'h02, 8'h11, 1'b0, 1'b0, 4'h0, 11'd1518, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}, // R6 runt before address
    '{16'd7,   8'h02, 8'h11, 1'b0, 1'b0, 4'h0, 11'd1518, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}  // R6 R3 reject meets runt end
  };

  task automatic run_and_check(input vec_t v, input bit gap, input string tag);
    int r0, c0, d0, b0, n0;
    logic [31:0] exp_stat;
    int exp_disc_at;
    r0 = n_req; c0 = n_commit; d0 = n_discard; b0 = n_babble; n0 = n_done;
    send_frame(int'(v.len), v.b0, v.fill, v.hit, v.prom, v.fl, gap, 3);
    check((n_req - r0) == ((v.len >= 7) ? 1 : 0), {tag, " R1 request count"}, n_req - r0, (v.len >= 7) ? 1 : 0);
    if (v.len >= 7 && !gap) begin
      check(req_at == 6, {tag, " R1 request position"}, req_at, 6);
      check(req_addr == {{5{v.fill}}, v.b0}, {tag, " R1 address bytes"}, req_addr, {{5{v.fill}}, v.b0});
    end
    check((n_commit - c0) == int'(v.e_commit), {tag, " R5 commit count"}, n_commit - c0, v.e_commit);
    if (v.e_commit) check(commit_at == 64, {tag, " R5 commit position"}, commit_at, 64);
    check((n_discard - d0) == int'(v.e_discard), {tag, " R3/R6 discard count"}, n_discard - d0, v.e_discard);
    if (v.e_discard && !gap) begin
      exp_disc_at = (!v.hit && !v.prom && v.len >= 7) ? 7 : int'(v.len);
      check(discard_at == exp_disc_at, {tag, " R6 discard position"}, discard_at, exp_disc_at);
    end
    check((n_babble - b0) == int'(v.e_babble), {tag, " R8 babble count"}, n_babble - b0, v.e_babble);
    if (v.e_babble) check(babble_at == int'(v.maxl) + 1, {tag, " R8 babble position"}, babble_at, int'(v.maxl) + 1);
    check((n_done - n0) == int'(v.e_done), {tag, " R7 done count"}, n_done - n0, v.e_done);
    if (v.e_done) begin
      exp_stat = {8'h00, v.e_flags, v.len};
      check(last_stat == exp_stat, {tag, " R7 status word"}, last_stat, exp_stat);
    end
  endtask

  initial begin
    #(10 * 200000);
    n_chk++; n_err++;
    $display("FAIL R10 watchdog: actual hung, expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    vec_t v;
    rst_n = 1'b0;
    cfg_maxlen_we = 1'b0; cfg_maxlen_data = '0;
    rx_valid = 1'b0; rx_data = '0; rx_last = 1'b0;
    {rx_end_dribble, rx_end_crc_err, rx_end_overrun, rx_end_trunc} = 4'b0;
    da_hit = 1'b0; promisc = 1'b0;
    repeat (3) @(negedge clk);
    check({da_req, fifo_commit, fifo_discard, babble, frame_done} == 5'b0 && frame_status == '0,
          "R7 reset outputs idle", {da_req, fifo_commit, fifo_discard, babble, frame_done, frame_status}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({fifo_commit, fifo_discard, babble, frame_done} == 4'b0, "R5 idle after reset",
          {fifo_commit, fifo_discard, babble, frame_done}, 0);

    // R9: reset maximum of 1518, so 1519 bytes is long and 1518 is not
    v = '{16'd1519, 8'h02, 8'h11, 1'b1, 1'b0, 4'h0, 11'd1518, 1'b1, 1'b0, 1'b1, 1'b1, 8'h10};
    run_and_check(v, 1'b0, "R9 reset max +1");
    v = '{16'd1518, 8'h02, 8'h11, 1'b1, 1'b0, 4'h0, 11'd1518, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00};
    run_and_check(v, 1'b0, "R9 reset max");

    for (int k = 0; k < NV; k++) begin
      set_max(VEC[k].maxl);
      run_and_check(VEC[k], 1'b0, $sformatf("vec%0d", k));
    end

    // R10: idle gaps carrying stray data and last flags are ignored
    set_max(11'd1518);
    v = '{16'd64, 8'h01, 8'h22, 1'b1, 1'b0, 4'h0, 11'd1518, 1'b1, 1'b0, 1'b1, 1'b0, 8'h20};
    run_and_check(v, 1'b1, "R10 gapped");

    // R10: two frames back to back with no idle cycle between them
    begin
      int c0, n0;
      c0 = n_commit; n0 = n_done;
      send_frame(64, 8'hFF, 8'hFF, 1'b1, 1'b0, 4'h0, 1'b0, 0);
      send_frame(65, 8'h02, 8'h11, 1'b1, 1'b0, 4'h2, 1'b0, 3);
      check((n_commit - c0) == 2, "R10 back-to-back commits", n_commit - c0, 2);
      check((n_done - n0) == 2, "R10 back-to-back done", n_done - n0, 2);
      check(last_stat == {8'h00, 8'h02, 16'd65}, "R10 second frame status", last_stat, {8'h00, 8'h02, 16'd65});
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule